// File: doc/BRIEF.md
# DRAM Bank Row-State Tracker

This block follows the row state of every bank of a multi-bank synchronous DRAM, one command per clock. It decodes activate, read, write, precharge and refresh commands that carry a bank address and a mode bit. For each bank it keeps a small state machine with four named states. BANK_IDLE means no row is open. BANK_OPEN means a row is open. BANK_BURST_AP means a read or write burst with automatic close is in flight. BANK_PRECH means the bank is counting down the precharge time. The mode bit means "every bank" on a precharge and "close after the burst" on a read or write.

The state transitions are as follows. BANK_IDLE goes to BANK_OPEN on a legal activate. BANK_OPEN goes to BANK_PRECH on a precharge, and to BANK_BURST_AP on a read or write with the mode bit set. BANK_BURST_AP goes to BANK_PRECH when the burst-length count expires. BANK_PRECH goes to BANK_IDLE when the precharge count expires. Each bank has its own down-counter. The block reports which banks can take an activate. It raises a one-cycle error flag for each illegal command. It also keeps a refresh interval timer and an internal refresh row counter.

Commands that break the rules are flagged and do not change any bank. A precharge to a bank that has nothing to close is dropped silently, and it leaves any running countdown untouched.

Top module: `dram_bank_tracker`

## Requirements
- R1: After reset every bank is in BANK_IDLE, so `bank_ready` is all ones, `cmd_err` is 0, `ref_row` is 0 and `ref_due` is 0.
- R2: Commands are encoded on `cmd_op` as 0 for NOP, 1 for activate, 2 for read, 3 for write, 4 for precharge and 5 for refresh. Codes 6 and 7 act as NOP. An activate to a bank in BANK_IDLE clears that bank's `bank_ready` bit after the clock edge that samples it and raises no error.
- R3: A precharge with `cmd_mode` low, sampled at edge k, moves the addressed open bank to BANK_PRECH. Its `bank_ready` bit returns high after edge k+TRP-1, so an activate sampled at edge k+TRP is legal.
- R4: A precharge with `cmd_mode` high moves every open bank to BANK_PRECH, whatever value `cmd_bank` holds.
- R5: A precharge to a bank in BANK_IDLE, BANK_PRECH or BANK_BURST_AP is a NOP. It raises no error and does not restart or stretch that bank's countdown.
- R6: A read or write with `cmd_mode` high, sampled at edge k on an open bank, closes that bank as if a precharge had been sampled at edge k+BL. The bank's `bank_ready` bit returns high after edge k+BL+TRP-1.
- R7: The close-after-burst request applies only to its own command. A read or write with `cmd_mode` low leaves the bank in BANK_OPEN indefinitely.
- R8: `cmd_err` is high for exactly the cycle after an illegal command. Illegal commands are: a read or write to a bank that is not in BANK_OPEN, an activate to a bank that is not in BANK_IDLE, and a refresh while any bank is not in BANK_IDLE. An illegal command changes no bank state.
- R9: A legal refresh (all banks idle) raises no error, increments `ref_row` by one (wrapping), and clears the interval timer.
- R10: `ref_due` goes high once TREFI cycles have passed since reset or since the last legal refresh. It stays high until the next legal refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_bank | input | BA_W (3) | Target bank |
| cmd_mode | input | 1 | All-bank select on precharge, close-after-burst on read/write |
| bank_ready | output | NUM_BANKS (8) | One bit per bank, high while the bank is in BANK_IDLE |
| cmd_err | output | 1 | One-cycle flag for an illegal command |
| ref_due | output | 1 | Refresh interval has elapsed |
| ref_row | output | ROW_W | Internal refresh row counter |

## Verification
The case that can overlap is a bank's own close-after-burst transition and an explicit all-bank precharge landing in the same cycle. The bench opens two banks and starts a closing burst on one of them. It then issues an all-bank precharge on the last cycle of that burst. The bursting bank must ignore the precharge and keep its own schedule, while the other bank starts precharging at once. The bench judges the result by the two banks' ready bits returning one cycle apart, with no error raised. A second overlap is checked on the cycle where a countdown ends: an activate one cycle too early must be flagged, and one on time must be accepted.

// File: rtl/dram_bank_pkg.sv
package dram_bank_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_ACT  = 3'd1,
        OP_RD   = 3'd2,
        OP_WR   = 3'd3,
        OP_PRE  = 3'd4,
        OP_REF  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } cmd_op_t;

    typedef enum logic [1:0] {
        BANK_IDLE     = 2'd0,
        BANK_OPEN     = 2'd1,
        BANK_BURST_AP = 2'd2,
        BANK_PRECH    = 2'd3
    } bank_st_t;

endpackage

// File: rtl/bank_fsm.sv
module bank_fsm
    import dram_bank_pkg::*;
#(
    parameter int TRP   = 4,
    parameter int BL    = 4,
    parameter int CNT_W = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     go_open,
    input  logic     go_close,
    input  logic     go_burst_ap,
    output bank_st_t state,
    output logic     ready
);

    localparam logic [CNT_W-1:0] TRP_LOAD = CNT_W'(TRP - 1);
    localparam logic [CNT_W-1:0] BL_LOAD  = CNT_W'(BL);

    bank_st_t         state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BANK_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            BANK_IDLE: begin
                if (go_open) state_d = BANK_OPEN;
            end
            BANK_OPEN: begin
                if (go_close) begin
                    state_d = BANK_PRECH;
                    cnt_d   = TRP_LOAD;
                end else if (go_burst_ap) begin
                    state_d = BANK_BURST_AP;
                    cnt_d   = BL_LOAD;
                end
            end
            BANK_BURST_AP: begin
                if (cnt_q == CNT_W'(1)) begin
                    state_d = BANK_PRECH;
                    cnt_d   = TRP_LOAD;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            BANK_PRECH: begin
                if (cnt_q <= CNT_W'(1)) begin
                    state_d = BANK_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: begin
                state_d = BANK_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    assign state = state_q;
    assign ready = (state_q == BANK_IDLE);

endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
    import dram_bank_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int BA_W      = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              cmd_op,
    input  logic [BA_W-1:0]         cmd_bank,
    input  logic                    cmd_mode,
    input  bank_st_t [NUM_BANKS-1:0] bank_st,
    output logic [NUM_BANKS-1:0]    open_v,
    output logic [NUM_BANKS-1:0]    close_v,
    output logic [NUM_BANKS-1:0]    burst_ap_v,
    output logic                    ref_ok,
    output logic                    err
);

    cmd_op_t  op;
    bank_st_t tgt_st;
    logic     all_idle;
    logic     err_d, err_q;

    assign op     = cmd_op_t'(cmd_op);
    assign tgt_st = bank_st[cmd_bank];

    always_comb begin
        all_idle = 1'b1;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (bank_st[i] != BANK_IDLE) all_idle = 1'b0;
        end
    end

    always_comb begin
        open_v     = '0;
        close_v    = '0;
        burst_ap_v = '0;
        ref_ok     = 1'b0;
        err_d      = 1'b0;
        unique case (op)
            OP_ACT: begin
                if (tgt_st == BANK_IDLE) open_v[cmd_bank] = 1'b1;
                else                     err_d = 1'b1;
            end
            OP_RD, OP_WR: begin
                if (tgt_st == BANK_OPEN) burst_ap_v[cmd_bank] = cmd_mode;
                else                     err_d = 1'b1;
            end
            OP_PRE: begin
                for (int i = 0; i < NUM_BANKS; i++) begin
                    if (bank_st[i] == BANK_OPEN &&
                        (cmd_mode || cmd_bank == BA_W'(i)))
                        close_v[i] = 1'b1;
                end
            end
            OP_REF: begin
                if (all_idle) ref_ok = 1'b1;
                else          err_d  = 1'b1;
            end
            OP_NOP, OP_RSV6, OP_RSV7: begin
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    assign err = err_q;

endmodule

// File: rtl/refresh_timer.sv
module refresh_timer #(
    parameter int TREFI  = 1000,
    parameter int ROW_W  = 4,
    parameter int REFI_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_ok,
    output logic             due,
    output logic [ROW_W-1:0] row
);

    localparam logic [REFI_W-1:0] LIMIT = REFI_W'(TREFI);

    logic [REFI_W-1:0] cnt_q;
    logic [ROW_W-1:0]  row_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            row_q <= '0;
        end else if (ref_ok) begin
            cnt_q <= '0;
            row_q <= row_q + ROW_W'(1);
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + REFI_W'(1);
        end
    end

    assign due = (cnt_q == LIMIT);
    assign row = row_q;

endmodule

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker
    import dram_bank_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int BA_W      = $clog2(NUM_BANKS),
    parameter int TRP       = 4,
    parameter int BL        = 4,
    parameter int TREFI     = 1000,
    parameter int ROW_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           cmd_op,
    input  logic [BA_W-1:0]      cmd_bank,
    input  logic                 cmd_mode,
    output logic [NUM_BANKS-1:0] bank_ready,
    output logic                 cmd_err,
    output logic                 ref_due,
    output logic [ROW_W-1:0]     ref_row
);

    localparam int MAXC   = (TRP > BL) ? TRP : BL;
    localparam int CNT_W  = $clog2(MAXC + 1);
    localparam int REFI_W = $clog2(TREFI + 1);

    bank_st_t [NUM_BANKS-1:0] bank_st;
    logic [NUM_BANKS-1:0]     open_v, close_v, burst_ap_v;
    logic                     ref_ok;

    cmd_decode #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_op     (cmd_op),
        .cmd_bank   (cmd_bank),
        .cmd_mode   (cmd_mode),
        .bank_st    (bank_st),
        .open_v     (open_v),
        .close_v    (close_v),
        .burst_ap_v (burst_ap_v),
        .ref_ok     (ref_ok),
        .err        (cmd_err)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_fsm #(.TRP(TRP), .BL(BL), .CNT_W(CNT_W)) u_fsm (
            .clk         (clk),
            .rst_n       (rst_n),
            .go_open     (open_v[b]),
            .go_close    (close_v[b]),
            .go_burst_ap (burst_ap_v[b]),
            .state       (bank_st[b]),
            .ready       (bank_ready[b])
        );
    end

    refresh_timer #(.TREFI(TREFI), .ROW_W(ROW_W), .REFI_W(REFI_W)) u_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_ok (ref_ok),
        .due    (ref_due),
        .row    (ref_row)
    );

endmodule

// File: rtl/dram_bank_tracker_checker.sv
module dram_bank_tracker_checker #(
    parameter int NUM_BANKS = 8,
    parameter int BA_W      = 3,
    parameter int ROW_W     = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2:0]           cmd_op,
    input logic [BA_W-1:0]      cmd_bank,
    input logic                 cmd_mode,
    input logic [NUM_BANKS-1:0] bank_ready,
    input logic                 cmd_err,
    input logic                 ref_due,
    input logic [ROW_W-1:0]     ref_row
);

    localparam logic [NUM_BANKS-1:0] ALL = '1;

    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> ($past(cmd_op) inside {3'd1, 3'd2, 3'd3, 3'd5}));

    assert_rdwr_idle_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_op == 3'd2 || cmd_op == 3'd3) && bank_ready[cmd_bank]) |=> cmd_err);

    assert_ref_busy_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 3'd5 && bank_ready != ALL) |=> cmd_err);

    assert_ref_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 3'd5 && bank_ready == ALL) |=> (!cmd_err && ref_row == $past(ref_row) + ROW_W'(1)));

    assert_due_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 3'd5 && bank_ready == ALL) |=> !ref_due);

    assert_row_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op != 3'd5) |=> $stable(ref_row));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        assert_ready_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(bank_ready[b]) |-> ($past(cmd_op) == 3'd1 && $past(cmd_bank) == BA_W'(b)));
    end

endmodule

bind dram_bank_tracker dram_bank_tracker_checker #(
    .NUM_BANKS(NUM_BANKS), .BA_W(BA_W), .ROW_W(ROW_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_op     (cmd_op),
    .cmd_bank   (cmd_bank),
    .cmd_mode   (cmd_mode),
    .bank_ready (bank_ready),
    .cmd_err    (cmd_err),
    .ref_due    (ref_due),
    .ref_row    (ref_row)
);

// File: tb/dram_bank_tracker_bench.sv
`timescale 1ns/1ps
module dram_bank_tracker_bench;

    localparam int NB    = 8;
    localparam int BAW   = 3;
    localparam int TRP   = 4;
    localparam int BL    = 4;
    localparam int TREFI = 40;
    localparam int RW    = 4;

    localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                           PRE = 3'd4, REF = 3'd5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [2:0]     cmd_op = NOP;
    logic [BAW-1:0] cmd_bank = '0;
    logic           cmd_mode = 1'b0;
    logic [NB-1:0]  bank_ready;
    logic           cmd_err, ref_due;
    logic [RW-1:0]  ref_row;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dram_bank_tracker #(.NUM_BANKS(NB), .TRP(TRP), .BL(BL), .TREFI(TREFI), .ROW_W(RW))
    u_dram_bank_tracker (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
        .cmd_mode(cmd_mode), .bank_ready(bank_ready), .cmd_err(cmd_err),
        .ref_due(ref_due), .ref_row(ref_row)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input int bank, input logic mode);
        cmd_op = op; cmd_bank = BAW'(bank); cmd_mode = mode;
        @(negedge clk);
        cmd_op = NOP; cmd_bank = '0; cmd_mode = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 ready", bank_ready, 8'hFF);
        chk("R1 err", cmd_err, 0);
        chk("R1 row", ref_row, 0);
        chk("R1 due", ref_due, 0);
    endtask

    task automatic t_refresh;
        idle(TREFI + 1);
        chk("R10 due set", ref_due, 1);
        issue(REF, 0, 0);
        chk("R9 no err", cmd_err, 0);
        chk("R9 row inc", ref_row, 1);
        chk("R10 due clear", ref_due, 0);
    endtask

    task automatic t_precharge_timing;
        issue(ACT, 1, 0);
        chk("R2 act", bank_ready[1], 0);
        chk("R2 no err", cmd_err, 0);
        issue(PRE, 1, 0);
        idle(TRP - 2);
        chk("R3 still busy", bank_ready[1], 0);
        issue(ACT, 1, 0);
        chk("R8 act too early", cmd_err, 1);
        chk("R3 ready on time", bank_ready[1], 1);
        issue(ACT, 1, 0);
        chk("R3 act on time", cmd_err, 0);
        chk("R3 act reopened", bank_ready[1], 0);
        issue(PRE, 1, 0);
        idle(TRP);
    endtask

    task automatic t_redundant_pre;
        issue(PRE, 4, 0);
        chk("R5 pre idle no err", cmd_err, 0);
        chk("R5 pre idle ready", bank_ready[4], 1);
        issue(ACT, 3, 0);
        issue(PRE, 3, 0);
        idle(1);
        issue(PRE, 3, 0);
        chk("R5 repeat no err", cmd_err, 0);
        chk("R5 not extended busy", bank_ready[3], 0);
        idle(1);
        chk("R5 not extended ready", bank_ready[3], 1);
    endtask

    task automatic t_errors;
        issue(RD, 2, 0);
        chk("R8 rd idle", cmd_err, 1);
        issue(NOP, 0, 0);
        chk("R8 pulse ends", cmd_err, 0);
        issue(ACT, 2, 0);
        issue(ACT, 2, 0);
        chk("R8 act open", cmd_err, 1);
        issue(REF, 0, 0);
        chk("R8 ref busy", cmd_err, 1);
        chk("R8 ref no row inc", ref_row, 1);
        issue(PRE, 2, 0);
        issue(WR, 2, 0);
        chk("R8 wr prech", cmd_err, 1);
        idle(TRP);
        chk("R8 state unchanged", bank_ready, 8'hFF);
    endtask

    task automatic t_no_persist;
        issue(ACT, 0, 0);
        issue(WR, 0, 1);
        idle(BL + TRP);
        chk("R6 auto closed", bank_ready[0], 1);
        issue(ACT, 0, 0);
        issue(RD, 0, 0);
        idle(BL + TRP + 4);
        chk("R7 stays open", bank_ready[0], 0);
        issue(RD, 0, 0);
        chk("R7 rd legal", cmd_err, 0);
        issue(PRE, 0, 0);
        idle(TRP);
    endtask

    task automatic t_auto_pre_timing;
        issue(ACT, 7, 0);
        issue(RD, 7, 1);
        chk("R6 no err", cmd_err, 0);
        idle(BL + TRP - 2);
        chk("R6 busy", bank_ready[7], 0);
        issue(ACT, 7, 0);
        chk("R6 early act err", cmd_err, 1);
        chk("R6 ready", bank_ready[7], 1);
    endtask

    task automatic t_overlap;
        issue(ACT, 2, 0);
        issue(ACT, 5, 0);
        issue(RD, 2, 1);
        idle(BL - 2);
        issue(PRE, 0, 1);
        chk("R4 no err", cmd_err, 0);
        chk("R4 both busy", {bank_ready[5], bank_ready[2]}, 2'b00);
        idle(TRP - 2);
        chk("R4 bank5 busy", bank_ready[5], 0);
        idle(1);
        chk("R4 bank5 ready", bank_ready[5], 1);
        chk("R5 bank2 own schedule", bank_ready[2], 0);
        idle(1);
        chk("R6 bank2 ready", bank_ready[2], 1);
    endtask

    task automatic t_pre_all_ignores_bank;
        issue(ACT, 1, 0);
        issue(ACT, 6, 0);
        issue(6, 1, 0);
        chk("R2 rsv code nop", bank_ready, 8'hBD);
        issue(PRE, 0, 1);
        chk("R4 all closing", bank_ready, 8'hBD);
        idle(TRP - 1);
        chk("R4 all idle", bank_ready, 8'hFF);
        issue(REF, 3, 0);
        chk("R9 second refresh", ref_row, 2);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_refresh();
        t_precharge_timing();
        t_redundant_pre();
        t_errors();
        t_no_persist();
        t_auto_pre_timing();
        idle(TRP + BL);
        t_overlap();
        t_pre_all_ignores_bank();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule